// File: doc/BRIEF.md
# Remapped Feature-Map Write Address Generator

This block turns a stream of output-unit strobes from a convolution engine into external-memory write addresses. Each unit holds `m` channel values at one pixel. The units of a layer arrive in a fixed order: across the columns of a row, then down the rows, then across the channel groups. For a layer whose output feeds a pointwise layer, the block places each unit at an address chosen so that the pointwise layer can read its input back as one long sequential run. For any other layer, it writes the units in plain arrival order.

Each layer occupies exactly as many address locations as it has units, which is `Fin*Fin*ceil(OC/m)`. After `init_i`, a sequential pass sums these counts layer by layer into a small base-address table. `done_o` rises when the pass ends. Before a layer starts producing units, `layer_start_i` with `layer_i` selects that layer's geometry, mode and base address, and clears the position counters. The channel-group width `m` is the power of two `2**M_LOG2`.

Top module: `fmap_wr_addr_gen`

## Requirements
- R1: While `rst_ni` is low and after it rises, `addr_vld_o` and `done_o` are low until the events below set them.
- R2: After the clock edge that samples `init_i` high, the table pass takes NL cycles, and `done_o` is high after the NL-th following edge.
- R3: The base of layer l is BASE_ADDR plus the sum, over layers j < l, of Fin_j*Fin_j*ceil(OC_j/m). The first unit after a layer start is written at that base in both modes.
- R4: In a remapped layer (its bit in `cfg_remap_i` is 1), the address is base + nb*(Fin*frag + slice) + blk, where nb = ceil(OC/m) and slice, frag and blk are 0-based counters.
- R5: slice counts fastest, from 0 to Fin-1. frag advances when slice wraps, from 0 to Fin-1. blk advances when frag wraps, from 0 to nb-1.
- R6: In a sequential layer (its `cfg_remap_i` bit is 0), the address is base + the 0-based index of the unit within the layer.
- R7: `addr_vld_o` is high exactly two clock edges after each edge that samples `unit_vld_i` high, and it is never high at any other time.
- R8: `layer_start_i` selects the geometry, mode and base of `layer_i` and restarts the counters at zero. This applies to units sampled after the start, including units of a layer that has already been visited.
- R9: After Fin*Fin*nb units of one layer, the counters wrap and the next unit lands at offset 0 again.
- R10: `done_o` stays high until the next `init_i`, and the edge that samples `init_i` drops it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Start the base-table pass |
| cfg_fin_i | input | NL*FIN_W | Per-layer feature-map side Fin; layer l is at bits [l*FIN_W +: FIN_W] |
| cfg_oc_i | input | NL*OC_W | Per-layer output channel count; layer l is at bits [l*OC_W +: OC_W] |
| cfg_remap_i | input | NL | Bit l set: layer l uses remapped placement |
| layer_start_i | input | 1 | Load the parameters of `layer_i` and clear the counters |
| layer_i | input | LW | Index of the layer being started |
| unit_vld_i | input | 1 | One output unit is produced in this cycle |
| addr_o | output | AW | Write address of the unit |
| addr_vld_o | output | 1 | `addr_o` is valid |
| done_o | output | 1 | The base table is filled |

## Verification
The assertions assume the following about the inputs. Every layer has Fin and OC of at least 1. Units are strobed only after `done_o` is high. No unit is strobed in the same cycle as `layer_start_i`. The per-layer configuration stays stable while the table pass runs. The bench sets a fixed configuration in which every layer is non-empty, and it waits for `done_o` before any layer starts. It raises `layer_start_i` in a cycle of its own, and it leaves gaps in the unit stream, so the in-flight addresses cross layer boundaries and counter wraps.

// File: rtl/wag_pkg.sv
package wag_pkg;
  typedef enum logic {FILL_IDLE, FILL_RUN} fill_state_e;
endpackage

// File: rtl/wag_base_table.sv
module wag_base_table #(
  parameter int unsigned NL        = 8,
  parameter int unsigned AW        = 32,
  parameter int unsigned LW        = 3,
  parameter logic [AW-1:0] BASE_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic [NL*AW-1:0]  cnt_i,
  input  logic [LW-1:0]     rd_idx_i,
  output logic [AW-1:0]     rd_base_o,
  output logic [NL*AW-1:0]  tbl_o,
  output logic              done_o
);
  import wag_pkg::*;

  fill_state_e     state_q;
  logic [LW-1:0]   idx_q;
  logic [AW-1:0]   acc_q;
  logic [AW-1:0]   tbl_q [NL];
  logic [AW-1:0]   cnt_sel;

  assign cnt_sel   = cnt_i[idx_q*AW +: AW];
  assign rd_base_o = tbl_q[rd_idx_i];

  for (genvar g = 0; g < NL; g++) begin : g_flat
    assign tbl_o[g*AW +: AW] = tbl_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FILL_IDLE;
      idx_q   <= '0;
      acc_q   <= '0;
      done_o  <= 1'b0;
      for (int i = 0; i < NL; i++) tbl_q[i] <= '0;
    end else if (init_i) begin
      state_q <= FILL_RUN;
      idx_q   <= '0;
      acc_q   <= BASE_ADDR;
      done_o  <= 1'b0;
    end else if (state_q == FILL_RUN) begin
      tbl_q[idx_q] <= acc_q;
      acc_q        <= acc_q + cnt_sel;
      if (idx_q == LW'(NL-1)) begin
        state_q <= FILL_IDLE;
        done_o  <= 1'b1;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wag_unit_counter.sv
module wag_unit_counter #(
  parameter int unsigned FIN_W = 8,
  parameter int unsigned NB_W  = 9,
  parameter int unsigned AW    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [FIN_W-1:0] fin_i,
  input  logic [NB_W-1:0]  nb_i,
  output logic [FIN_W-1:0] slice_o,
  output logic [FIN_W-1:0] frag_o,
  output logic [NB_W-1:0]  blk_o,
  output logic [AW-1:0]    idx_o
);
  logic last_s, last_f, last_b;

  assign last_s = (slice_o == fin_i - 1'b1);
  assign last_f = (frag_o  == fin_i - 1'b1);
  assign last_b = (blk_o   == nb_i  - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slice_o <= '0;
      frag_o  <= '0;
      blk_o   <= '0;
      idx_o   <= '0;
    end else if (clr_i) begin
      slice_o <= '0;
      frag_o  <= '0;
      blk_o   <= '0;
      idx_o   <= '0;
    end else if (adv_i) begin
      slice_o <= last_s ? '0 : slice_o + 1'b1;
      if (last_s) begin
        frag_o <= last_f ? '0 : frag_o + 1'b1;
        if (last_f) blk_o <= last_b ? '0 : blk_o + 1'b1;
      end
      idx_o <= (last_s && last_f && last_b) ? '0 : idx_o + 1'b1;
    end
  end
endmodule

// File: rtl/wag_addr_pipe.sv
module wag_addr_pipe #(
  parameter int unsigned FIN_W = 8,
  parameter int unsigned NB_W  = 9,
  parameter int unsigned AW    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [FIN_W-1:0] slice_i,
  input  logic [FIN_W-1:0] frag_i,
  input  logic [NB_W-1:0]  blk_i,
  input  logic [AW-1:0]    idx_i,
  input  logic [FIN_W-1:0] fin_i,
  input  logic [NB_W-1:0]  nb_i,
  input  logic [AW-1:0]    base_i,
  input  logic             remap_i,
  output logic [AW-1:0]    addr_o,
  output logic             vld_o
);
  localparam int unsigned LIN_W = 2*FIN_W;

  logic             p1_vld, p1_remap;
  logic [LIN_W-1:0] p1_lin;
  logic [NB_W-1:0]  p1_blk, p1_nb;
  logic [AW-1:0]    p1_idx, p1_base;
  logic [AW-1:0]    off;

  // stage 1: row-major position inside the channel group
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p1_vld   <= 1'b0;
      p1_remap <= 1'b0;
      p1_lin   <= '0;
      p1_blk   <= '0;
      p1_nb    <= '0;
      p1_idx   <= '0;
      p1_base  <= '0;
    end else begin
      p1_vld <= vld_i;
      if (vld_i) begin
        p1_lin   <= LIN_W'(fin_i) * LIN_W'(frag_i) + LIN_W'(slice_i);
        p1_blk   <= blk_i;
        p1_nb    <= nb_i;
        p1_idx   <= idx_i;
        p1_base  <= base_i;
        p1_remap <= remap_i;
      end
    end
  end

  // stage 2: stride by group count, add base
  assign off = p1_remap ? (AW'(p1_nb) * AW'(p1_lin) + AW'(p1_blk)) : p1_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      addr_o <= '0;
    end else begin
      vld_o <= p1_vld;
      if (p1_vld) addr_o <= p1_base + off;
    end
  end
endmodule

// File: rtl/fmap_wr_addr_gen.sv
module fmap_wr_addr_gen #(
  parameter int unsigned   NL        = 8,
  parameter int unsigned   FIN_W     = 8,
  parameter int unsigned   OC_W      = 11,
  parameter int unsigned   M_LOG2    = 3,
  parameter int unsigned   AW        = 32,
  parameter logic [AW-1:0] BASE_ADDR = '0,
  parameter int unsigned   LW        = $clog2(NL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic [NL*FIN_W-1:0] cfg_fin_i,
  input  logic [NL*OC_W-1:0]  cfg_oc_i,
  input  logic [NL-1:0]     cfg_remap_i,
  input  logic              layer_start_i,
  input  logic [LW-1:0]     layer_i,
  input  logic              unit_vld_i,
  output logic [AW-1:0]     addr_o,
  output logic              addr_vld_o,
  output logic              done_o
);
  localparam int unsigned   NB_W   = OC_W + 1 - M_LOG2;
  localparam int unsigned   OCX    = OC_W + 1;
  localparam logic [OC_W:0] M_MASK = OCX'((1 << M_LOG2) - 1);

  logic [FIN_W-1:0] fin_a [NL];
  logic [NB_W-1:0]  nb_a  [NL];
  logic [AW-1:0]    cnt_a [NL];
  logic [NL*AW-1:0] cnt_flat, tbl_flat;
  logic [AW-1:0]    rd_base;

  for (genvar g = 0; g < NL; g++) begin : g_layer
    logic [OC_W:0] oc_up;
    assign fin_a[g] = cfg_fin_i[g*FIN_W +: FIN_W];
    assign oc_up    = {1'b0, cfg_oc_i[g*OC_W +: OC_W]} + M_MASK;
    assign nb_a[g]  = NB_W'(oc_up >> M_LOG2);
    assign cnt_a[g] = AW'(fin_a[g]) * AW'(fin_a[g]) * AW'(nb_a[g]);
    assign cnt_flat[g*AW +: AW] = cnt_a[g];
  end

  wag_base_table #(.NL(NL), .AW(AW), .LW(LW), .BASE_ADDR(BASE_ADDR)) u_tbl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .init_i    (init_i),
    .cnt_i     (cnt_flat),
    .rd_idx_i  (layer_i),
    .rd_base_o (rd_base),
    .tbl_o     (tbl_flat),
    .done_o    (done_o)
  );

  logic [FIN_W-1:0] cur_fin;
  logic [NB_W-1:0]  cur_nb;
  logic             cur_remap;
  logic [AW-1:0]    cur_base, cur_count;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_fin   <= '0;
      cur_nb    <= '0;
      cur_remap <= 1'b0;
      cur_base  <= '0;
      cur_count <= '0;
    end else if (layer_start_i) begin
      cur_fin   <= fin_a[layer_i];
      cur_nb    <= nb_a[layer_i];
      cur_remap <= cfg_remap_i[layer_i];
      cur_base  <= rd_base;
      cur_count <= cnt_a[layer_i];
    end
  end

  logic [FIN_W-1:0] slice, frag;
  logic [NB_W-1:0]  blk;
  logic [AW-1:0]    uidx;

  wag_unit_counter #(.FIN_W(FIN_W), .NB_W(NB_W), .AW(AW)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (layer_start_i),
    .adv_i   (unit_vld_i),
    .fin_i   (cur_fin),
    .nb_i    (cur_nb),
    .slice_o (slice),
    .frag_o  (frag),
    .blk_o   (blk),
    .idx_o   (uidx)
  );

  wag_addr_pipe #(.FIN_W(FIN_W), .NB_W(NB_W), .AW(AW)) u_pipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (unit_vld_i),
    .slice_i (slice),
    .frag_i  (frag),
    .blk_i   (blk),
    .idx_i   (uidx),
    .fin_i   (cur_fin),
    .nb_i    (cur_nb),
    .base_i  (cur_base),
    .remap_i (cur_remap),
    .addr_o  (addr_o),
    .vld_o   (addr_vld_o)
  );
endmodule

// File: rtl/fmap_wr_addr_gen_chk.sv
module fmap_wr_addr_gen_chk #(
  parameter int unsigned NL = 8,
  parameter int unsigned AW = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             init_i,
  input logic             unit_vld_i,
  input logic             addr_vld_o,
  input logic [AW-1:0]    addr_o,
  input logic             done_o,
  input logic [AW-1:0]    cur_base,
  input logic [AW-1:0]    cur_count,
  input logic [NL*AW-1:0] tbl_flat
);
  a_r7_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unit_vld_i |-> ##2 addr_vld_o);

  a_r7_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_vld_o |-> $past(unit_vld_i, 2));

  a_r9_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_vld_o |-> ((addr_o - $past(cur_base, 2)) < $past(cur_count, 2)));

  a_r10_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !init_i) |=> done_o);

  a_r10_init_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> !done_o);

  for (genvar g = 0; g + 1 < NL; g++) begin : g_ord
    a_r3_base_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (tbl_flat[(g+1)*AW +: AW] > tbl_flat[g*AW +: AW]));
  end
endmodule

bind fmap_wr_addr_gen fmap_wr_addr_gen_chk #(.NL(NL), .AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .init_i     (init_i),
  .unit_vld_i (unit_vld_i),
  .addr_vld_o (addr_vld_o),
  .addr_o     (addr_o),
  .done_o     (done_o),
  .cur_base   (cur_base),
  .cur_count  (cur_count),
  .tbl_flat   (tbl_flat)
);

// File: tb/sim_fmap_wr_addr_gen.sv
`timescale 1ns/1ps
module sim_fmap_wr_addr_gen;
  localparam int NL = 8, FIN_W = 8, OC_W = 11, M_LOG2 = 3, AW = 32, LW = 3;
  localparam logic [AW-1:0] BASE = 32'h0000_4000;

  logic clk_i = 1'b0, rst_ni = 1'b0, init_i = 1'b0;
  logic [NL*FIN_W-1:0] cfg_fin_i;
  logic [NL*OC_W-1:0]  cfg_oc_i;
  logic [NL-1:0]       cfg_remap_i;
  logic layer_start_i = 1'b0, unit_vld_i = 1'b0;
  logic [LW-1:0] layer_i = '0;
  logic [AW-1:0] addr_o;
  logic addr_vld_o, done_o;

  always #10 clk_i = ~clk_i;

  fmap_wr_addr_gen #(.NL(NL), .FIN_W(FIN_W), .OC_W(OC_W), .M_LOG2(M_LOG2),
                     .AW(AW), .BASE_ADDR(BASE)) u0 (.*);

  int fin_t [NL] = '{3, 4, 2, 5, 1, 3, 2, 4};
  int oc_t  [NL] = '{16, 20, 8, 9, 30, 1, 64, 24};
  bit rmp_t [NL] = '{1, 0, 1, 1, 0, 1, 0, 1};
  longint base_t [NL];
  int nchk = 0, nerr = 0;

  function automatic int nb_of(int l);
    return (oc_t[l] + (1 << M_LOG2) - 1) >> M_LOG2;
  endfunction
  function automatic int tot_of(int l);
    return fin_t[l] * fin_t[l] * nb_of(l);
  endfunction

  // reference model: expected output per sampled edge
  int m_layer = 0, m_n = 0;
  bit     qv [$];
  longint qa [$];
  string  qt [$];

  always @(posedge clk_i) begin
    if (rst_ni) begin
      bit v; longint a; string t;
      v = unit_vld_i; a = 0; t = "R7";
      if (layer_start_i) begin
        m_layer = int'(layer_i); m_n = 0;
      end else if (unit_vld_i) begin
        int tot, n, f, s, b, fin, nb;
        fin = fin_t[m_layer]; nb = nb_of(m_layer); tot = tot_of(m_layer);
        n = m_n % tot;
        s = n % fin; f = (n / fin) % fin; b = n / (fin * fin);
        a = base_t[m_layer] + (rmp_t[m_layer] ? longint'(nb * (fin * f + s) + b) : longint'(n));
        if (m_n >= tot && n == 0) t = "R9";
        else if (n == 0) t = "R3/R8";
        else if (rmp_t[m_layer]) t = "R4/R5";
        else t = "R6";
        m_n++;
      end
      qv.push_back(v); qa.push_back(a); qt.push_back(t);
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (qv.size() == 2) begin
        bit v; longint a; string t;
        v = qv.pop_front(); a = qa.pop_front(); t = qt.pop_front();
        nchk++;
        if (addr_vld_o !== v) begin
          nerr++;
          $display("FAIL R7 addr_vld_o: actual %0b expected %0b", addr_vld_o, v);
        end else if (v) begin
          nchk++;
          if (addr_o !== a[AW-1:0]) begin
            nerr++;
            $display("FAIL %s addr_o: actual %h expected %h", t, addr_o, a[AW-1:0]);
          end
        end
      end else begin
        nchk++;
        if (addr_vld_o !== 1'b0) begin
          nerr++;
          $display("FAIL R1 addr_vld_o: actual %0b expected 0", addr_vld_o);
        end
      end
    end
  end

  task automatic chk_done(bit exp, string tag);
    nchk++;
    if (done_o !== exp) begin
      nerr++;
      $display("FAIL %s done_o: actual %0b expected %0b", tag, done_o, exp);
    end
  endtask

  // R2 / R10: init pass timing
  task automatic do_init();
    @(negedge clk_i) init_i = 1'b1;
    @(negedge clk_i) init_i = 1'b0;
    chk_done(1'b0, "R10");
    for (int k = 1; k <= NL; k++) begin
      @(negedge clk_i);
      chk_done(k == NL, "R2");
    end
  endtask

  task automatic run_layer(int l, int nunits);
    @(negedge clk_i);
    layer_start_i = 1'b1; layer_i = LW'(l);
    @(negedge clk_i);
    layer_start_i = 1'b0;
    for (int i = 0; i < nunits; i++) begin
      unit_vld_i = 1'b1;
      @(negedge clk_i);
      unit_vld_i = 1'b0;
      if (i % 3 == 2) @(negedge clk_i);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    nerr++;
    $display("FAIL R7 watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    longint acc;
    acc = BASE;
    for (int l = 0; l < NL; l++) begin
      cfg_fin_i[l*FIN_W +: FIN_W] = FIN_W'(fin_t[l]);
      cfg_oc_i[l*OC_W +: OC_W]    = OC_W'(oc_t[l]);
      cfg_remap_i[l]              = rmp_t[l];
      base_t[l] = acc;
      acc += tot_of(l);
    end
    repeat (3) @(negedge clk_i);
    nchk++;
    if (addr_vld_o !== 1'b0 || done_o !== 1'b0) begin
      nerr++;
      $display("FAIL R1 reset: actual vld=%0b done=%0b expected 0 0", addr_vld_o, done_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_done(1'b0, "R1");
    do_init();
    for (int l = 0; l < NL; l++) run_layer(l, tot_of(l) + 3);
    run_layer(0, 5);           // revisit after other layers
    run_layer(3, tot_of(3) + 1);
    repeat (2) @(negedge clk_i);
    chk_done(1'b1, "R10");
    do_init();
    run_layer(7, 10);
    repeat (4) @(negedge clk_i);
    finish_run();
  end
endmodule